// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block sits between the execute stage of a 32-bit processor and a 32-bit data memory port. For each access it adds a base register to an offset, which is either a second register or a sign-extended immediate. It then aligns the resulting address to the access size by masking its low bits, without raising any trap.

For stores it drives byte-lane enables and a write word. In the write word the byte or halfword being stored is copied into every lane. For loads, the memory returns a word one cycle after the request. The block picks the addressed byte or halfword out of that word and zero-extends it to 32 bits. It does this using the size and low address bits it registered when the request was issued.

Lanes are big-endian: address offset 0 maps to bits 31:24.

Top module: `ldst_lane_unit`

## Requirements
- R1: The effective address is `base_val` plus the offset, modulo 2^32. The offset is `off_imm` sign-extended from 16 bits when `use_imm` is 1, and `off_reg` otherwise.
- R2: For a byte access (`req_size` = 2'b00), `mem_addr` equals the effective address unchanged.
- R3: For a halfword access (`req_size` = 2'b01), `mem_addr` is the effective address with bit 0 forced to 0.
- R4: For a word access (`req_size` = 2'b10, and also the code 2'b11), `mem_addr` is the effective address with bits 1:0 forced to 0.
- R5: `mem_be[3]` marks bits 31:24 and `mem_be[0]` marks bits 7:0. A byte access at offset k enables only `mem_be[3-k]`. A halfword enables 4'b1100 at offset 0 and 4'b0011 at offset 2. A word enables 4'b1111. Without a request, `mem_be` is 0.
- R6: On a store, `mem_wdata` is one of the following. For a byte, the low byte of `store_data` is copied into all four lanes. For a halfword, the low halfword is copied into both halves. For a word, it is `store_data` itself. Without a store, `mem_wdata` is 0.
- R7: One cycle after a byte load, `ld_data` is the lane picked by the captured offset k (bits 31-8k down to 24-8k of `mem_rdata`), zero-extended.
- R8: One cycle after a halfword load, `ld_data` is bits 31:16 of `mem_rdata` (offset 0) or bits 15:0 (offset 2), zero-extended.
- R9: One cycle after a word load, `ld_data` equals `mem_rdata`.
- R10: `mem_req` follows `req_valid`, and `mem_we` is `req_valid` and `req_store` together. `ld_valid` is 1 exactly in the cycle after a load request, even when loads are issued back to back.
- R11: While `rst_n` is low, `ld_valid` and `ld_data` are 0.
- R12: `ld_data` is 0 whenever `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| use_imm | input | 1 | Select immediate offset |
| base_val | input | 32 | Base register value |
| off_reg | input | 32 | Register offset |
| off_imm | input | 16 | Immediate offset, sign-extended |
| store_data | input | 32 | Data register for stores |
| mem_rdata | input | 32 | Read word, valid the cycle after a load request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Aligned address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Zero-extended load result |

## Verification
The assertions assume several things about the inputs:
- `mem_rdata` is meaningful only in the cycle after a load request.
- `req_size` always holds one of the four codes.
- Nothing is known about the request fields before the first post-reset cycle.

The zero-extension checks rely on the registered size rather than on the current inputs, so they stay valid when a new request overlaps a returning load. The stimulus holds all inputs at zero during reset and changes them only on the falling edge. It presents a fresh read word in every cycle, so a load result is never tied to a stale value. It also issues loads back to back, so captured offsets and new requests coexist.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_WIDE = 2'b11
  } acc_size_e;

  function automatic logic is_word(acc_size_e sz);
    return (sz == ACC_WORD) || (sz == ACC_WIDE);
  endfunction

  // lane i (bits DATA_W-1-8i) is enabled for this size and offset
  function automatic logic lane_hit(acc_size_e sz, logic [OFF_W-1:0] off, int lane);
    logic [OFF_W-1:0] ln;
    ln = OFF_W'(lane);
    case (sz)
      ACC_BYTE: return off == ln;
      ACC_HALF: return off[OFF_W-1] == ln[OFF_W-1];
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] off_reg,
  input  logic [IMM_W-1:0]  off_imm,
  input  logic              use_imm,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea_raw,
  output logic [ADDR_W-1:0] ea_aligned
);
  localparam int EXT_W = ADDR_W - IMM_W;

  function automatic logic [ADDR_W-1:0] sext_imm(logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] align(logic [ADDR_W-1:0] a, acc_size_e sz);
    logic [ADDR_W-1:0] r;
    r = a;
    if (sz == ACC_HALF) r[0] = 1'b0;
    if (is_word(sz)) r[1:0] = 2'b00;
    return r;
  endfunction

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset     = use_imm ? sext_imm(off_imm) : off_reg;
    ea_raw     = base_val + offset;
    ea_aligned = align(ea_raw, size);
  end
endmodule

// File: rtl/ldst_store_lane.sv
module ldst_store_lane
  import ldst_pkg::*;
(
  input  logic               active,
  input  logic               is_store,
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   off,
  input  logic [DATA_W-1:0]  sdata,
  output logic [LANES-1:0]   be,
  output logic [DATA_W-1:0]  wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * i;
    logic [7:0] lane_byte;
    always_comb begin
      case (size)
        ACC_BYTE: lane_byte = sdata[7:0];
        ACC_HALF: lane_byte = (i % 2 == 1) ? sdata[7:0] : sdata[15:8];
        default:  lane_byte = sdata[HI -: 8];
      endcase
    end
    assign be[LANES-1-i]   = active & lane_hit(size, off, i);
    assign wdata[HI -: 8]  = (active & is_store) ? lane_byte : 8'h00;
  end
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_fire,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output acc_size_e         cap_size,
  output logic [DATA_W-1:0] ld_data
);
  logic [OFF_W-1:0] cap_off;
  logic [7:0]       lane_byte [LANES];
  logic [DATA_W-1:0] picked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      cap_size <= ACC_BYTE;
      cap_off  <= '0;
    end else begin
      ld_valid <= load_fire;
      if (load_fire) begin
        cap_size <= size;
        cap_off  <= off;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign lane_byte[i] = rdata[DATA_W-1-8*i -: 8];
  end

  always_comb begin
    case (cap_size)
      ACC_BYTE: picked = {{(DATA_W-8){1'b0}}, lane_byte[cap_off]};
      ACC_HALF: picked = {{(DATA_W-16){1'b0}},
                          lane_byte[{cap_off[OFF_W-1], 1'b0}],
                          lane_byte[{cap_off[OFF_W-1], 1'b1}]};
      default:  picked = rdata;
    endcase
    ld_data = ld_valid ? picked : '0;
  end
endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              use_imm,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] off_reg,
  input  logic [IMM_W-1:0]  off_imm,
  input  logic [DATA_W-1:0] store_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  acc_size_e         size_e;
  acc_size_e         ld_size_q;
  logic [ADDR_W-1:0] ea_raw;
  logic [ADDR_W-1:0] ea_aligned;
  logic [OFF_W-1:0]  low_off;
  logic              load_fire;

  assign size_e    = acc_size_e'(req_size);
  assign low_off   = ea_raw[OFF_W-1:0];
  assign load_fire = req_valid & ~req_store;
  assign mem_req   = req_valid;
  assign mem_we    = req_valid & req_store;
  assign mem_addr  = ea_aligned;

  ldst_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
    .base_val(base_val), .off_reg(off_reg), .off_imm(off_imm),
    .use_imm(use_imm), .size(size_e),
    .ea_raw(ea_raw), .ea_aligned(ea_aligned)
  );

  ldst_store_lane u_store (
    .active(req_valid), .is_store(req_store), .size(size_e),
    .off(low_off), .sdata(store_data), .be(mem_be), .wdata(mem_wdata)
  );

  ldst_load_extract u_load (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .size(size_e),
    .off(low_off), .rdata(mem_rdata), .ld_valid(ld_valid),
    .cap_size(ld_size_q), .ld_data(ld_data)
  );
endmodule

// File: rtl/ldst_checker.sv
module ldst_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  req_size,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        ld_valid,
  input logic [31:0] ld_data,
  input logic        load_fire,
  input logic [1:0]  ld_size_q
);
  p_load_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> ld_valid);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> !ld_valid);
  p_we_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  p_half_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'b01) |-> (mem_addr[0] == 1'b0));
  p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size[1]) |-> (mem_addr[1:0] == 2'b00));
  p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'b00) |-> ($countones(mem_be) == 1));
  p_half_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'b01) |-> ($countones(mem_be) == 2));
  p_idle_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (mem_be == 4'b0000));
  p_byte_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b00) |->
      (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[15:8] == mem_wdata[7:0]));
  p_byte_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size_q == 2'b00) |-> (ld_data[31:8] == 24'h0));
  p_half_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size_q == 2'b01) |-> (ld_data[31:16] == 16'h0));
  p_quiet_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (ld_data == 32'h0));
endmodule

bind ldst_lane_unit ldst_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_size(req_size), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .ld_valid(ld_valid), .ld_data(ld_data),
  .load_fire(load_fire), .ld_size_q(ld_size_q)
);

// File: tb/sim_ldst_lane_unit.sv
module sim_ldst_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, use_imm = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base_val = '0, off_reg = '0, store_data = '0, mem_rdata = '0;
  logic [15:0] off_imm = '0;
  logic        mem_req, mem_we, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;

  int n_cmp = 0, n_bad = 0;
  bit prev_ld = 0;
  logic [1:0] prev_sz = 0, prev_off = 0;

  always #2 clk = ~clk;

  ldst_lane_unit u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] x_addr(logic [31:0] ea, logic [1:0] sz);
    if (sz == 0) return ea;
    if (sz == 1) return ea - (ea % 2);
    return ea - (ea % 4);
  endfunction

  function automatic logic [3:0] x_be(logic [1:0] sz, logic [1:0] off);
    if (sz == 0) return 4'b1000 >> off;
    if (sz == 1) return off[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] x_wd(logic [1:0] sz, logic [31:0] d);
    if (sz == 0) return {24'h0, d[7:0]} * 32'h0101_0101;
    if (sz == 1) return {16'h0, d[15:0]} * 32'h0001_0001;
    return d;
  endfunction

  function automatic logic [31:0] x_ld(logic [1:0] sz, logic [1:0] off, logic [31:0] w);
    if (sz == 0) return (w >> (8 * (3 - off))) & 32'hFF;
    if (sz == 1) return (w >> (16 * (1 - off[1]))) & 32'hFFFF;
    return w;
  endfunction

  task automatic step(bit v, bit st, logic [1:0] sz, bit ui, logic [31:0] b,
                      logic [31:0] orr, logic [15:0] im, logic [31:0] sd,
                      logic [31:0] rd);
    logic [31:0] ea;
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz; use_imm = ui;
    base_val = b; off_reg = orr; off_imm = im; store_data = sd; mem_rdata = rd;
    #1;
    chk("R10 ld_valid", {31'h0, ld_valid}, {31'h0, prev_ld});
    if (prev_ld) begin
      if (prev_sz == 0)      chk("R7 byte load", ld_data, x_ld(prev_sz, prev_off, rd));
      else if (prev_sz == 1) chk("R8 half load", ld_data, x_ld(prev_sz, prev_off, rd));
      else                   chk("R9 word load", ld_data, x_ld(prev_sz, prev_off, rd));
    end else chk("R12 quiet ld_data", ld_data, 32'h0);
    ea = b + (ui ? {{16{im[15]}}, im} : orr);
    chk("R10 mem_req", {31'h0, mem_req}, {31'h0, v});
    chk("R10 mem_we", {31'h0, mem_we}, {31'h0, v & st});
    if (v) begin
      if (sz == 0)      chk("R1 R2 byte addr", mem_addr, x_addr(ea, sz));
      else if (sz == 1) chk("R3 half addr", mem_addr, x_addr(ea, sz));
      else              chk("R4 word addr", mem_addr, x_addr(ea, sz));
      chk("R5 lanes", {28'h0, mem_be}, {28'h0, x_be(sz, ea[1:0])});
      chk("R6 wdata", mem_wdata, st ? x_wd(sz, sd) : 32'h0);
    end else begin
      chk("R5 idle lanes", {28'h0, mem_be}, 32'h0);
      chk("R6 idle wdata", mem_wdata, 32'h0);
    end
    prev_ld = v && !st; prev_sz = sz; prev_off = ea[1:0];
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset ld_valid", {31'h0, ld_valid}, 32'h0);
    chk("R11 reset ld_data", ld_data, 32'h0);
    rst_n = 1'b1;
    rw = 32'hA1B2_C3D4;
    for (int pat = 0; pat < 3; pat++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int st = 0; st < 2; st++)
            for (int ui = 0; ui < 2; ui++) begin
              logic [31:0] b;
              b = (pat == 2) ? 32'hFFFF_FFF0 : (32'h9E37_79B0 * (pat + 1)) & ~32'h3;
              rw = (rw << 5) ^ (rw >> 3) ^ 32'h5A5A_0F0F ^ off;
              step(1'b1, st[0], sz[1:0], ui[0], b,
                   32'h0001_0000 * pat + off + 32'h20,
                   pat[0] ? (16'hFFF0 + 16'(off)) : (16'h0040 + 16'(off)),
                   rw ^ 32'h1357_9BDF, rw);
            end
    // back-to-back byte loads walking every lane
    for (int k = 0; k < 8; k++)
      step(1'b1, 1'b0, 2'b00, 1'b0, 32'h100, 32'(k % 4), 16'h0, 32'h0,
           32'h1122_3344 + 32'h0101_0101 * k);
    // idle cycles and a store after a load
    step(1'b0, 1'b0, 2'b01, 1'b0, 32'h4, 32'h2, 16'h0, 32'hFFFF_FFFF, 32'hCAFE_F00D);
    step(1'b1, 1'b0, 2'b01, 1'b1, 32'h8, 32'h0, 16'hFFFE, 32'h0, 32'hDEAD_BEEF);
    step(1'b1, 1'b1, 2'b00, 1'b0, 32'hFFFF_FFFF, 32'h2, 16'h0, 32'h0000_00A5, 32'h0BAD_F00D);
    step(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 32'h0, 16'h0, 32'h0, 32'h7777_7777);
    step(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 32'h0, 16'h0, 32'h0, 32'h8888_8888);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule